// File: doc/BRIEF.md
# Activate Spacing Guard

This block sits beside a DRAM command scheduler and answers one question every cycle: if a row activation were issued now to a given rank and bank, how many cycles would still have to pass before it is legal? The scheduler presents the candidate rank and bank on the query inputs. The block returns the remaining wait, and a flag that is high when the wait is zero. Every command the scheduler actually commits is reported on the record inputs, so the block can update its history.

Four spacing rules apply to an activation. The first is the row cycle time to the same bank. The second is the activate-to-activate spacing within the same rank. The third is the refresh recovery time after an all-bank refresh of the same rank. The fourth is a rolling window per rank that admits only a set number of activations within a set span. The window holds either four or two entries, chosen by parameter. The reported wait is the largest remaining wait over all the rules. Time is a free-running cycle counter. A history entry retires once its rule can no longer impose a wait, so counter wrap cannot alias an old entry.

Top module: `act_spacing_guard`

## Requirements
- R1: After reset no history exists, and the wait is 0 for every rank and bank.
- R2: After an activation to a bank at cycle t, a query for that same rank and bank at cycle t+k reports at least T_RC-k while k < T_RC.
- R3: After an activation to a rank at cycle t, a query for any bank of that rank at cycle t+k reports at least T_RRD-k. An activation to another rank adds no wait.
- R4: After an all-bank refresh of a rank at cycle t, a query for that rank at cycle t+k reports at least T_RFC-k. Other ranks are unaffected.
- R5: Each rank holds the start cycles of its most recent WIN_DEPTH activations. When WIN_DEPTH activations are held and the oldest was at cycle t0, the query at cycle t reports at least T_WIN-(t-t0). With fewer held, the window adds no wait.
- R6: An activation recorded into a full window discards that rank's oldest entry. The window is then measured from the next-oldest entry.
- R7: The reported wait equals the largest remaining wait among the applicable rules, and never goes below zero. With no new record and an unchanged query, a nonzero wait falls by exactly one per cycle.
- R8: A record takes effect from the following cycle. A query in the same cycle sees the earlier history.
- R9: act_ok is high exactly when act_wait is zero.
- R10: The record command encoding is 2'b01 activation and 2'b10 all-bank refresh. Codes 2'b00 and 2'b11 change nothing, even with rec_valid high.
- R11: With WIN_DEPTH=2, the window admits two activations per T_WIN span instead of four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| qry_rank | input | RANK_W | Rank of the candidate activation |
| qry_bank | input | BANK_W | Bank within the rank of the candidate activation |
| rec_valid | input | 1 | A committed command is reported this cycle |
| rec_cmd | input | 2 | Committed command code (01 activation, 10 all-bank refresh) |
| rec_rank | input | RANK_W | Rank of the committed command |
| rec_bank | input | BANK_W | Bank of the committed command |
| act_wait | output | DLY_W | Cycles still to wait before the candidate may issue |
| act_ok | output | 1 | Candidate may issue this cycle |

## Verification
On every cycle, the assertions check the lower bound that each recorded activation or refresh places on the next cycle's wait for the same bank or rank. They also check that an undisturbed wait counts down by exactly one. Ignored command codes are covered by this countdown check. Some behaviour only the bench scenarios can show: the exact value of the maximum across rules, the window filling and dropping its oldest entry, isolation between ranks, and the two-entry window variant. The bench compares these against a cycle-counting model.

// File: rtl/act_spacing_pkg.sv
`timescale 1ns/1ps
package act_spacing_pkg;
    typedef enum logic [1:0] {
        CMD_IDLE   = 2'b00,
        CMD_ACT    = 2'b01,
        CMD_REFALL = 2'b10,
        CMD_RSVD   = 2'b11
    } rec_cmd_e;

    function automatic int max_of3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction
endpackage

// File: rtl/act_stamp_slot.sv
`timescale 1ns/1ps
// One history entry: remembers a start cycle and reports the remaining
// part of a fixed spacing limit measured from it.
module act_stamp_slot #(
    parameter int TS_W  = 8,
    parameter int LIMIT = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TS_W-1:0] now,
    input  logic            rec,
    output logic [TS_W-1:0] rem
);
    typedef struct packed {
        logic            vld;
        logic [TS_W-1:0] ts;
    } slot_t;

    slot_t           st_d, st_q;
    logic [TS_W-1:0] elapsed;
    logic            live;

    always_comb begin
        elapsed = now - st_q.ts;
        live    = st_q.vld && (elapsed < TS_W'(LIMIT));
        rem     = live ? (TS_W'(LIMIT) - elapsed) : '0;
        st_d    = st_q;
        if (rec) begin
            st_d.vld = 1'b1;
            st_d.ts  = now;
        end else if (st_q.vld && !live) begin
            // limit fully served: retire so a wrapped counter never aliases
            st_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/act_roll_window.sv
`timescale 1ns/1ps
// Per-rank rolling window of recent activation start cycles.
// Entry 0 is the oldest. Expired heads are retired one per cycle.
module act_roll_window #(
    parameter int TS_W  = 8,
    parameter int DEPTH = 4,
    parameter int LIMIT = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TS_W-1:0] now,
    input  logic            rec,
    output logic [TS_W-1:0] rem
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][TS_W-1:0] ts;
        logic [CNT_W-1:0]           cnt;
    } win_t;

    win_t            st_d, st_q;
    logic [TS_W-1:0] head_el;
    logic            full;
    logic            head_exp;
    int              pos;

    always_comb begin
        head_el  = now - st_q.ts[0];
        full     = (st_q.cnt == CNT_W'(DEPTH));
        head_exp = (st_q.cnt != '0) && (head_el >= TS_W'(LIMIT));
        rem      = (full && !head_exp) ? (TS_W'(LIMIT) - head_el) : '0;

        st_d = st_q;
        pos  = 0;
        if (head_exp) begin
            for (int i = 0; i < DEPTH - 1; i++) st_d.ts[i] = st_d.ts[i+1];
            st_d.cnt = st_q.cnt - 1'b1;
        end
        if (rec) begin
            pos = int'(st_d.cnt);
            if (pos == DEPTH) begin
                // full: oldest falls out, newest lands at the tail
                for (int i = 0; i < DEPTH - 1; i++) st_d.ts[i] = st_d.ts[i+1];
                pos = DEPTH - 1;
            end else begin
                st_d.cnt = st_d.cnt + 1'b1;
            end
            for (int i = 0; i < DEPTH; i++) begin
                if (i == pos) st_d.ts[i] = now;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/act_spacing_guard.sv
`timescale 1ns/1ps
module act_spacing_guard #(
    parameter int NUM_RANKS      = 2,
    parameter int BANKS_PER_RANK = 8,
    parameter int T_RC           = 12,
    parameter int T_RRD          = 4,
    parameter int T_RFC          = 20,
    parameter int T_WIN          = 16,
    parameter int WIN_DEPTH      = 4,
    localparam int RANK_W  = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
    localparam int BANK_W  = (BANKS_PER_RANK > 1) ? $clog2(BANKS_PER_RANK) : 1,
    localparam int MAX_LIM = act_spacing_pkg::max_of3(T_RC, T_RRD,
                             act_spacing_pkg::max_of3(T_RFC, T_WIN, 1)),
    localparam int DLY_W   = $clog2(MAX_LIM + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RANK_W-1:0] qry_rank,
    input  logic [BANK_W-1:0] qry_bank,
    input  logic              rec_valid,
    input  logic [1:0]        rec_cmd,
    input  logic [RANK_W-1:0] rec_rank,
    input  logic [BANK_W-1:0] rec_bank,
    output logic [DLY_W-1:0]  act_wait,
    output logic              act_ok
);
    import act_spacing_pkg::*;

    localparam int TS_W    = $clog2(MAX_LIM + 2) + 1;
    localparam int N_BANKS = NUM_RANKS * BANKS_PER_RANK;

    typedef struct packed {
        logic [TS_W-1:0] now;
    } top_t;

    top_t top_d, top_q;

    logic                 rec_act, rec_ref;
    logic [NUM_RANKS-1:0] rank_act_hit, rank_ref_hit;
    logic [N_BANKS-1:0]   bank_act_hit;
    logic [TS_W-1:0]      bank_rem [N_BANKS];
    logic [TS_W-1:0]      rrd_rem  [NUM_RANKS];
    logic [TS_W-1:0]      rfc_rem  [NUM_RANKS];
    logic [TS_W-1:0]      win_rem  [NUM_RANKS];
    logic [TS_W-1:0]      pick_max;

    always_comb begin
        top_d.now = top_q.now + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign rec_act = rec_valid && (rec_cmd == CMD_ACT);
    assign rec_ref = rec_valid && (rec_cmd == CMD_REFALL);

    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
        assign rank_act_hit[r] = rec_act && (rec_rank == RANK_W'(r));
        assign rank_ref_hit[r] = rec_ref && (rec_rank == RANK_W'(r));

        act_stamp_slot #(.TS_W(TS_W), .LIMIT(T_RRD)) u_rrd (
            .clk(clk), .rst_n(rst_n), .now(top_q.now),
            .rec(rank_act_hit[r]), .rem(rrd_rem[r]));

        act_stamp_slot #(.TS_W(TS_W), .LIMIT(T_RFC)) u_rfc (
            .clk(clk), .rst_n(rst_n), .now(top_q.now),
            .rec(rank_ref_hit[r]), .rem(rfc_rem[r]));

        act_roll_window #(.TS_W(TS_W), .DEPTH(WIN_DEPTH), .LIMIT(T_WIN)) u_win (
            .clk(clk), .rst_n(rst_n), .now(top_q.now),
            .rec(rank_act_hit[r]), .rem(win_rem[r]));

        for (genvar b = 0; b < BANKS_PER_RANK; b++) begin : g_bank
            localparam int IDX = r * BANKS_PER_RANK + b;
            assign bank_act_hit[IDX] = rank_act_hit[r] && (rec_bank == BANK_W'(b));

            act_stamp_slot #(.TS_W(TS_W), .LIMIT(T_RC)) u_rc (
                .clk(clk), .rst_n(rst_n), .now(top_q.now),
                .rec(bank_act_hit[IDX]), .rem(bank_rem[IDX]));
        end
    end

    // select the candidate's entries and take the largest remaining wait
    always_comb begin
        pick_max = '0;
        for (int r = 0; r < NUM_RANKS; r++) begin
            if (qry_rank == RANK_W'(r)) begin
                if (rrd_rem[r] > pick_max) pick_max = rrd_rem[r];
                if (rfc_rem[r] > pick_max) pick_max = rfc_rem[r];
                if (win_rem[r] > pick_max) pick_max = win_rem[r];
                for (int b = 0; b < BANKS_PER_RANK; b++) begin
                    if (qry_bank == BANK_W'(b) &&
                        bank_rem[r*BANKS_PER_RANK+b] > pick_max)
                        pick_max = bank_rem[r*BANKS_PER_RANK+b];
                end
            end
        end
    end

    assign act_wait = DLY_W'(pick_max);
    assign act_ok   = (pick_max == '0);
endmodule

// File: rtl/act_spacing_guard_chk.sv
`timescale 1ns/1ps
module act_spacing_guard_chk #(
    parameter int T_RC   = 12,
    parameter int T_RRD  = 4,
    parameter int T_RFC  = 20,
    parameter int RANK_W = 1,
    parameter int BANK_W = 3,
    parameter int DLY_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [RANK_W-1:0] qry_rank,
    input logic [BANK_W-1:0] qry_bank,
    input logic              rec_valid,
    input logic [1:0]        rec_cmd,
    input logic [RANK_W-1:0] rec_rank,
    input logic [BANK_W-1:0] rec_bank,
    input logic [DLY_W-1:0]  act_wait,
    input logic              act_ok
);
    a_r2_bank_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_cmd == 2'b01) |=>
        (qry_rank != $past(rec_rank) || qry_bank != $past(rec_bank) ||
         int'(act_wait) >= T_RC - 1));

    a_r3_rank_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_cmd == 2'b01) |=>
        (qry_rank != $past(rec_rank) || int'(act_wait) >= T_RRD - 1));

    a_r4_refresh_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_cmd == 2'b10) |=>
        (qry_rank != $past(rec_rank) || int'(act_wait) >= T_RFC - 1));

    a_r7_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (!(rec_valid && (rec_cmd == 2'b01 || rec_cmd == 2'b10)) && act_wait != '0) |=>
        (!$stable(qry_rank) || !$stable(qry_bank) ||
         act_wait == $past(act_wait) - 1'b1));

    a_r9_ok_flag: assert property (@(posedge clk) disable iff (!rst_n)
        act_ok |-> (act_wait == '0));
endmodule

bind act_spacing_guard act_spacing_guard_chk #(
    .T_RC(T_RC), .T_RRD(T_RRD), .T_RFC(T_RFC),
    .RANK_W(RANK_W), .BANK_W(BANK_W), .DLY_W(DLY_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .qry_rank(qry_rank), .qry_bank(qry_bank),
    .rec_valid(rec_valid), .rec_cmd(rec_cmd), .rec_rank(rec_rank),
    .rec_bank(rec_bank), .act_wait(act_wait), .act_ok(act_ok)
);

// File: tb/act_spacing_guard_tb_top.sv
`timescale 1ns/1ps
module act_spacing_guard_tb_top;
    localparam int NR = 2, NB = 8;
    localparam int RC = 12, RRD = 4, RFC = 20;
    localparam int WIN4 = 16, WIN2 = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [0:0] qry_rank = '0, rec_rank = '0;
    logic [2:0] qry_bank = '0, rec_bank = '0;
    logic       rec_valid = 1'b0;
    logic [1:0] rec_cmd = 2'b00;
    logic [4:0] wait4, wait2;
    logic       ok4, ok2;

    always #4 clk = ~clk;   // 125 MHz

    act_spacing_guard #(.NUM_RANKS(NR), .BANKS_PER_RANK(NB), .T_RC(RC), .T_RRD(RRD),
        .T_RFC(RFC), .T_WIN(WIN4), .WIN_DEPTH(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .qry_rank(qry_rank), .qry_bank(qry_bank),
        .rec_valid(rec_valid), .rec_cmd(rec_cmd), .rec_rank(rec_rank),
        .rec_bank(rec_bank), .act_wait(wait4), .act_ok(ok4));

    act_spacing_guard #(.NUM_RANKS(NR), .BANKS_PER_RANK(NB), .T_RC(RC), .T_RRD(RRD),
        .T_RFC(RFC), .T_WIN(WIN2), .WIN_DEPTH(2)) dut_two_i (
        .clk(clk), .rst_n(rst_n), .qry_rank(qry_rank), .qry_bank(qry_bank),
        .rec_valid(rec_valid), .rec_cmd(rec_cmd), .rec_rank(rec_rank),
        .rec_bank(rec_bank), .act_wait(wait2), .act_ok(ok2));

    typedef struct {
        int    e4;
        int    e2;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0, n_bad = 0;
    int   cyc = 0;
    bit   done = 0;

    // reference history, -1 means never written
    int bank_t[NR][NB];
    int rrd_t[NR];
    int rfc_t[NR];
    int w4[NR][$];
    int w2[NR][$];

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    function automatic int lim(int t, int span);
        if (t < 0) return 0;
        return (span - (cyc - t) > 0) ? span - (cyc - t) : 0;
    endfunction

    function automatic int model(int r, int b, int depth);
        int w, v;
        w = lim(bank_t[r][b], RC);
        v = lim(rrd_t[r], RRD); if (v > w) w = v;
        v = lim(rfc_t[r], RFC); if (v > w) w = v;
        if (depth == 4 && w4[r].size() == 4) begin
            v = lim(w4[r][0], WIN4); if (v > w) w = v;
        end
        if (depth == 2 && w2[r].size() == 2) begin
            v = lim(w2[r][0], WIN2); if (v > w) w = v;
        end
        return w;
    endfunction

    // one cycle: query, optional record, expected pushed before model update
    task automatic drive(int qr, int qb, bit rv, int rc, int rr, int rb, string tag);
        exp_t e;
        @(negedge clk);
        qry_rank = qr[0:0]; qry_bank = qb[2:0];
        rec_valid = rv; rec_cmd = rc[1:0]; rec_rank = rr[0:0]; rec_bank = rb[2:0];
        e.e4 = model(qr, qb, 4);
        e.e2 = model(qr, qb, 2);
        e.tag = tag;
        exp_q.push_back(e);
        if (rv && rc == 1) begin
            bank_t[rr][rb] = cyc;
            rrd_t[rr] = cyc;
            if (w4[rr].size() == 4) void'(w4[rr].pop_front());
            w4[rr].push_back(cyc);
            if (w2[rr].size() == 2) void'(w2[rr].pop_front());
            w2[rr].push_back(cyc);
        end else if (rv && rc == 2) begin
            rfc_t[rr] = cyc;
        end
    endtask

    task automatic idle(int qr, int qb, int n, string tag);
        for (int i = 0; i < n; i++) drive(qr, qb, 0, 0, 0, 0, tag);
    endtask

    task automatic check(int act, int expv, string tag, string what);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    // monitor: compares each cycle's outputs late in the cycle
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(int'(wait4), e.e4, e.tag, "wait depth4");
                check(int'(wait2), e.e2, e.tag, "wait depth2 (R11)");
                check(int'(ok4), (e.e4 == 0) ? 1 : 0, e.tag, "ok flag (R9)");
            end
        end
    end

    initial begin
        #1600000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int c0;
        for (int r = 0; r < NR; r++) begin
            rrd_t[r] = -1; rfc_t[r] = -1;
            for (int b = 0; b < NB; b++) bank_t[r][b] = -1;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        for (int r = 0; r < NR; r++)
            for (int b = 0; b < NB; b++) drive(r, b, 0, 0, 0, 0, "R1");

        // R8: same-cycle query sees old history; R2 countdown on that bank
        drive(0, 1, 1, 1, 0, 1, "R8");
        idle(0, 1, RC + 1, "R2");
        // R3: other bank of rank 0 and other rank
        drive(0, 5, 1, 1, 0, 1, "R3");
        drive(0, 5, 0, 0, 0, 0, "R3");
        drive(1, 1, 0, 0, 0, 0, "R3 other rank");
        idle(0, 1, 2, "R7 max rc over rrd");
        idle(0, 3, RC, "R3");

        // R4: refresh of rank 1
        drive(1, 0, 1, 2, 1, 0, "R4");
        idle(1, 0, 5, "R4");
        drive(0, 0, 0, 0, 0, 0, "R4 other rank");
        idle(1, 6, RFC, "R4");

        // R10: ignored codes leave bank 3 of rank 0 idle
        drive(0, 3, 1, 0, 0, 3, "R10");
        drive(0, 3, 1, 3, 0, 3, "R10");
        idle(0, 3, 2, "R10");
        idle(0, 0, 30, "R10 settle");

        // R5/R11: fill rank 1 window with activations two cycles apart
        for (int k = 0; k < 4; k++) begin
            drive(1, 7, 1, 1, 1, k, "R5");
            drive(1, 7, 0, 0, 0, 0, "R5");
        end
        idle(1, 7, 3, "R5 window wait");
        // R6: fifth activation drops the oldest entry
        drive(1, 6, 1, 1, 1, 4, "R6");
        idle(1, 7, WIN4 + 2, "R6");

        // R7: several rules active together on rank 0
        c0 = cyc;
        drive(0, 2, 1, 2, 0, 0, "R7");
        drive(0, 2, 1, 1, 0, 2, "R7");
        idle(0, 2, RFC + 2, "R7");

        repeat (3) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule